// File: doc/BRIEF.md
# Presettable Cascadable Binary Counter

This block is a small synchronous up-counter with a parallel preset. Its state steps through every value of a `WIDTH`-bit binary word (sixteen values at the default width of 4) and returns to zero after the all-ones value. An active-low clear empties the state at once, without waiting for a clock. An active-low load copies a data word into the state on the next rising edge. Two active-high count enables must both be high for the state to advance; otherwise the value holds.

The terminal-count output goes high when the state is all ones and the trickle enable is high. It is a plain combinational function of the state and that one enable. This lets several copies form a wider counter. In ripple wiring, each stage's terminal count feeds the next stage's trickle enable. In lookahead wiring, the first stage's terminal count also drives the parallel enable of every later stage, so only a short path has to settle before the clock edge. Because the output can glitch, it is a data-level enable and must never serve as a clock or as a clear.

Top module: `pcnt_stage`

## Requirements
- R1: While `clr_n` is low, `q` is all zeros immediately, without a clock edge, whatever `load_n`, `din` and the enables are.
- R2: With `clr_n` high and `load_n` low, the rising edge copies `din` into `q`, whatever `en_par` and `en_trk` are.
- R3: With `clr_n` and `load_n` high and both `en_par` and `en_trk` high, each rising edge adds one to `q`.
- R4: With `clr_n` and `load_n` high and either enable low, `q` keeps its value across the edge.
- R5: Counting from the all-ones state (15 at the default width) gives zero on the next edge.
- R6: `tc` is 1 exactly when `q` is all ones and `en_trk` is 1. `en_par` and `load_n` have no influence on it.
- R7: `tc` follows a change of `en_trk` within the same clock period, with no register in between.
- R8: Three stages in ripple wiring form a 12-bit counter. The first stage has `en_trk` as the chain enable and `en_par` tied high. Each later stage takes the previous `tc` on `en_trk` and has `en_par` tied high. The chain loads, clears, holds, carries across stage boundaries, and wraps from 4095 to 0.
- R9: Three stages in lookahead wiring form a 12-bit counter. The first stage is wired as in R8. The first stage's `tc` drives `en_par` of both later stages, and `en_trk` still chains from `tc` to `tc`. This chain behaves the same as the one in R8.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| clr_n | input | 1 | Asynchronous clear, active low, highest precedence |
| load_n | input | 1 | Synchronous parallel load, active low |
| din | input | WIDTH | Preset value copied in on a load |
| en_par | input | 1 | Parallel count enable, active high |
| en_trk | input | 1 | Trickle count enable, active high; also gates `tc` |
| q | output | WIDTH | Counter state |
| tc | output | 1 | Terminal count: state all ones and trickle enable high |

## Verification
Two pairs of functions can claim the same cycle. A load can coincide with both enables high, and a clear can coincide with a pending load. The bench provokes the first by presenting a preset word while both enables are high, and expects the preset value rather than the incremented one. It provokes the second by dropping the clear in the middle of a cycle in which load and both enables are already asserted; it expects zero at once, and expects zero still after the edge. The reference model gives clear, load, count and hold that precedence, and every result is compared against it one edge later.

// File: rtl/pcnt_pkg.sv
// Shared types for the presettable counter stage.
// Assumes: the clear is handled outside the synchronous mode set.
package pcnt_pkg;

    // Synchronous action taken on the next rising edge
    typedef enum logic [1:0] {
        MODE_HOLD  = 2'd0,
        MODE_COUNT = 2'd1,
        MODE_LOAD  = 2'd2
    } pcnt_mode_e;

endpackage

// File: rtl/pcnt_mode_dec.sv
// Mode decoder: picks the synchronous action from load and the two enables.
// Assumes: load outranks counting; counting needs both enables.
module pcnt_mode_dec
    import pcnt_pkg::*;
(
    input  logic       load_n,
    input  logic       en_par,
    input  logic       en_trk,
    output pcnt_mode_e mode
);

    // Priority choice: load, then count, then hold
    always_comb begin
        if (!load_n) begin
            mode = MODE_LOAD;
        end else if (en_par && en_trk) begin
            mode = MODE_COUNT;
        end else begin
            mode = MODE_HOLD;
        end
    end

endmodule

// File: rtl/pcnt_incr.sv
// Incrementer built as a bitwise carry chain.
// Also reports whether the input is all ones; the terminal count reuses that carry out.
// Assumes: WIDTH >= 1; the sum wraps naturally at the top.
module pcnt_incr #(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] val,
    output logic [WIDTH-1:0] val_inc,
    output logic             all_ones
);

    logic [WIDTH:0] carry;

    assign carry[0] = 1'b1;

    // One half-adder cell per bit
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        assign val_inc[i]  = val[i] ^ carry[i];
        assign carry[i+1]  = val[i] & carry[i];
    end

    assign all_ones = carry[WIDTH];

endmodule

// File: rtl/pcnt_state_reg.sv
// State register with an asynchronous active-low clear.
// Applies the decoded synchronous mode on each rising edge.
// Assumes: the clear is released synchronously to clk by the surrounding logic.
module pcnt_state_reg
    import pcnt_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             clr_n,
    input  pcnt_mode_e       mode,
    input  logic [WIDTH-1:0] load_val,
    input  logic [WIDTH-1:0] inc_val,
    output logic [WIDTH-1:0] state
);

    // Clear at once on clr_n low, otherwise load, count or hold on the edge
    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) begin
            state <= '0;
        end else begin
            case (mode)
                MODE_LOAD:  state <= load_val;
                MODE_COUNT: state <= inc_val;
                default:    state <= state;
            endcase
        end
    end

endmodule

// File: rtl/pcnt_stage.sv
// One cascadable counter stage: preset, count, hold, asynchronous clear.
// tc is combinational (all ones AND trickle enable) so stages can chain.
// Assumes: tc is used only as a data-level enable, never as a clock or a clear.
module pcnt_stage
    import pcnt_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             clr_n,
    input  logic             load_n,
    input  logic [WIDTH-1:0] din,
    input  logic             en_par,
    input  logic             en_trk,
    output logic [WIDTH-1:0] q,
    output logic             tc
);

    pcnt_mode_e       mode;
    logic [WIDTH-1:0] q_inc;
    logic             q_full;

    pcnt_mode_dec u_dec (
        .load_n (load_n),
        .en_par (en_par),
        .en_trk (en_trk),
        .mode   (mode)
    );

    pcnt_incr #(.WIDTH(WIDTH)) u_inc (
        .val      (q),
        .val_inc  (q_inc),
        .all_ones (q_full)
    );

    pcnt_state_reg #(.WIDTH(WIDTH)) u_reg (
        .clk      (clk),
        .clr_n    (clr_n),
        .mode     (mode),
        .load_val (din),
        .inc_val  (q_inc),
        .state    (q)
    );

    // Terminal count gated only by the trickle enable
    assign tc = q_full & en_trk;

endmodule

// File: rtl/pcnt_stage_chk.sv
// Property checker for pcnt_stage, attached with bind.
// Assumes: the bench drives clr_n low shortly after time zero.
module pcnt_stage_chk #(
    parameter int WIDTH = 4
) (
    input logic             clk,
    input logic             clr_n,
    input logic             load_n,
    input logic [WIDTH-1:0] din,
    input logic             en_par,
    input logic             en_trk,
    input logic [WIDTH-1:0] q,
    input logic             tc
);

    localparam logic [WIDTH-1:0] ONES = '1;

    // Clear seen at an edge must already show an empty state
    always @(posedge clk) begin
        if (clr_n === 1'b0) begin
            // R1
            clear_zero_chk: assert (q == '0);
        end
    end

    // R2
    load_copy_chk: assert property (@(posedge clk) disable iff (!clr_n)
        !load_n |=> q == $past(din));

    // R3
    count_step_chk: assert property (@(posedge clk) disable iff (!clr_n)
        (load_n && en_par && en_trk) |=> q == WIDTH'($past(q) + 1'b1));

    // R4
    hold_keep_chk: assert property (@(posedge clk) disable iff (!clr_n)
        (load_n && !(en_par && en_trk)) |=> $stable(q));

    // R5
    wrap_zero_chk: assert property (@(posedge clk) disable iff (!clr_n)
        (load_n && en_par && en_trk && q == ONES) |=> q == '0);

    // R6
    tc_needs_full_chk: assert property (@(posedge clk) disable iff (!clr_n)
        tc |-> (q == ONES));

    // R6
    tc_needs_trk_chk: assert property (@(posedge clk) disable iff (!clr_n)
        !en_trk |-> !tc);

    // R6
    tc_rises_chk: assert property (@(posedge clk) disable iff (!clr_n)
        (q == ONES && en_trk) |-> tc);

endmodule

bind pcnt_stage pcnt_stage_chk #(.WIDTH(WIDTH)) u_chk (
    .clk    (clk),
    .clr_n  (clr_n),
    .load_n (load_n),
    .din    (din),
    .en_par (en_par),
    .en_trk (en_trk),
    .q      (q),
    .tc     (tc)
);

// File: tb/pcnt_stage_tb.sv
`timescale 1ns/100ps
// Scoreboard bench: a single stage plus ripple and lookahead 12-bit chains.
module pcnt_stage_tb;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    // Single-stage stimulus
    logic       clr_n  = 1'b1;
    logic       load_n = 1'b1;
    logic [3:0] din    = '0;
    logic       ep     = 1'b0;
    logic       et     = 1'b0;
    logic [3:0] q;
    logic       tc;

    // Chain stimulus shared by both chains
    logic        c_clr_n  = 1'b1;
    logic        c_load_n = 1'b1;
    logic [11:0] c_din    = '0;
    logic        c_en     = 1'b0;

    logic [3:0] rq0, rq1, rq2, lq0, lq1, lq2;
    logic       rt0, rt1, rt2, lt0, lt1, lt2;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    logic [3:0]  m_q = '0;
    logic [11:0] m_c = '0;

    typedef struct {
        logic [3:0]  q;
        logic        tc;
        logic [11:0] cv;
        string       req;
    } sb_item_t;

    sb_item_t sb[$];

    pcnt_stage #(.WIDTH(4)) u_dut (
        .clk(clk), .clr_n(clr_n), .load_n(load_n), .din(din),
        .en_par(ep), .en_trk(et), .q(q), .tc(tc)
    );

    // Ripple chain (R8)
    pcnt_stage #(.WIDTH(4)) u_r0 (.clk(clk), .clr_n(c_clr_n), .load_n(c_load_n),
        .din(c_din[3:0]), .en_par(1'b1), .en_trk(c_en), .q(rq0), .tc(rt0));
    pcnt_stage #(.WIDTH(4)) u_r1 (.clk(clk), .clr_n(c_clr_n), .load_n(c_load_n),
        .din(c_din[7:4]), .en_par(1'b1), .en_trk(rt0), .q(rq1), .tc(rt1));
    pcnt_stage #(.WIDTH(4)) u_r2 (.clk(clk), .clr_n(c_clr_n), .load_n(c_load_n),
        .din(c_din[11:8]), .en_par(1'b1), .en_trk(rt1), .q(rq2), .tc(rt2));

    // Lookahead chain (R9)
    pcnt_stage #(.WIDTH(4)) u_l0 (.clk(clk), .clr_n(c_clr_n), .load_n(c_load_n),
        .din(c_din[3:0]), .en_par(1'b1), .en_trk(c_en), .q(lq0), .tc(lt0));
    pcnt_stage #(.WIDTH(4)) u_l1 (.clk(clk), .clr_n(c_clr_n), .load_n(c_load_n),
        .din(c_din[7:4]), .en_par(lt0), .en_trk(lt0), .q(lq1), .tc(lt1));
    pcnt_stage #(.WIDTH(4)) u_l2 (.clk(clk), .clr_n(c_clr_n), .load_n(c_load_n),
        .din(c_din[11:8]), .en_par(lt0), .en_trk(lt1), .q(lq2), .tc(lt2));

    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    // Driver: apply one cycle of stimulus and queue the reference result
    task automatic step(input logic s_clr, input logic s_ld, input logic [3:0] s_d,
                        input logic s_ep, input logic s_et,
                        input logic k_clr, input logic k_ld, input logic [11:0] k_d,
                        input logic k_en, input string rq);
        sb_item_t it;
        @(negedge clk);
        clr_n = s_clr; load_n = s_ld; din = s_d; ep = s_ep; et = s_et;
        c_clr_n = k_clr; c_load_n = k_ld; c_din = k_d; c_en = k_en;
        if (!s_clr)              m_q = '0;
        else if (!s_ld)          m_q = s_d;
        else if (s_ep && s_et)   m_q = 4'(m_q + 1);
        if (!k_clr)              m_c = '0;
        else if (!k_ld)          m_c = k_d;
        else if (k_en)           m_c = 12'(m_c + 1);
        it.q   = m_q;
        it.tc  = (m_q == 4'hF) && s_et;
        it.cv  = m_c;
        it.req = rq;
        sb.push_back(it);
    endtask

    // Monitor: compare one queued item per edge, away from the edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb.size() > 0) begin
                sb_item_t it;
                it = sb.pop_front();
                chk({it.req, " q"}, 32'(q), 32'(it.q));
                chk({it.req, " tc"}, 32'(tc), 32'(it.tc));
                chk("R8 ripple", 32'({rq2, rq1, rq0}), 32'(it.cv));
                chk("R9 lookahead", 32'({lq2, lq1, lq0}), 32'(it.cv));
            end
        end
    end

    // Watchdog: a hung run counts as a failure
    initial begin
        #800000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    // Main sequence
    initial begin
        #0.5;
        clr_n = 1'b0; c_clr_n = 1'b0;
        #2.5;
        chk("R1 reset q", 32'(q), 0);
        chk("R1 reset tc", 32'(tc), 0);
        chk("R1 reset chain", 32'({rq2, rq1, rq0}), 0);

        // Loads win over enables
        step(1, 0, 4'd5, 0, 0, 1, 1, 12'd0, 0, "R2 load idle");
        step(1, 0, 4'd12, 1, 1, 1, 0, 12'h0FE, 0, "R2 load over count");
        step(1, 1, 4'd0, 1, 1, 1, 1, 12'd0, 1, "R3 count");
        step(1, 1, 4'd0, 1, 1, 1, 1, 12'd0, 1, "R3 count");
        step(1, 1, 4'd0, 1, 1, 1, 1, 12'd0, 1, "R6 tc at full");
        step(1, 1, 4'd0, 0, 1, 1, 1, 12'd0, 0, "R4 hold ep low tc R6");
        step(1, 1, 4'd0, 1, 1, 1, 0, 12'd4093, 0, "R5 wrap");
        step(1, 1, 4'd0, 1, 0, 1, 1, 12'd0, 1, "R4 hold et low");
        step(1, 1, 4'd0, 0, 0, 1, 1, 12'd0, 1, "R4 hold both low");
        step(1, 0, 4'd15, 1, 0, 1, 1, 12'd0, 1, "R6 full et low");
        step(1, 1, 4'd0, 0, 0, 1, 0, 12'd0, 1, "R4 chain clear");

        // R7: tc tracks et inside a period
        @(posedge clk); #1.5;
        @(negedge clk);
        c_clr_n = 1'b1; c_load_n = 1'b1; c_en = 1'b0;
        et = 1'b1; ep = 1'b0; load_n = 1'b1;
        #0.5 chk("R7 tc rise", 32'(tc), 1);
        et = 1'b0;
        #0.5 chk("R7 tc fall", 32'(tc), 0);

        // R1: clear mid-cycle against a pending load and count
        @(posedge clk); #1.5;
        @(negedge clk);
        load_n = 1'b0; din = 4'd9; ep = 1'b1; et = 1'b1;
        #0.5 clr_n = 1'b0;
        #0.3 chk("R1 async q", 32'(q), 0);
        chk("R1 async tc", 32'(tc), 0);
        @(posedge clk); #1.5;
        chk("R1 over load", 32'(q), 0);
        m_q = '0;

        // Mixed patterns over a full chain wrap
        for (int i = 0; i < 4800; i++) begin
            step(1, (i % 37) != 0, 4'(i), (i % 3) != 0, (i % 5) != 0,
                 1, 1, 12'd0, (i % 8) != 0, "R3 mixed");
        end
        step(1, 1, 4'd0, 0, 0, 0, 0, 12'd77, 1, "R1 chain clear");

        @(posedge clk); #1.5;
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule